// File: doc/BRIEF.md
# Operand Addressing Mode Engine

This block turns an operand specifier into a value for an ALU. A caller presents a mode code, a base register selector, an index register selector, a literal field and a size code, and pulses start. The engine reads up to two registers through its register read ports. It computes an effective address and issues one or two data-memory reads. For the post-increment and post-decrement modes, it also writes the updated base register back through its single write port.

Register and immediate operands are produced without touching memory. All other modes go through a request/valid memory handshake. The memory side may take any number of cycles to answer. The engine returns to idle after a one-cycle done pulse, and the operand is valid during that pulse.

Top module: `opnd_addr_engine`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, done_o, mem_req_o and rf_we_o are low.
- R2: Mode code 0, and every unused code from 10 to 15, returns the base register contents. done_o rises in the cycle after start is taken, and no memory request is made.
- R3: Mode code 1 returns field_i as the operand, in the cycle after start, with no memory request.
- R4: Mode code 2 reads memory at field_i plus the base register. Mode code 3 reads memory at the base register value. The operand is the returned data.
- R5: Mode code 4 reads memory at the sum of the base and index registers. Mode code 5 reads memory at field_i. The operand is the returned data.
- R6: Mode code 9 reads memory at field_i plus the base register plus the index register shifted left by log2(d).
- R7: The operand size d is taken from size_i: code 0 gives 1, code 1 gives 2, and codes 2 and 3 give 4.
- R8: Mode code 6 makes exactly two memory handshakes. The first read is at the base register, the second read is at the data returned by the first, and the operand is the second returned data.
- R9: Mode codes 7 and 8 read memory at the unmodified base register. In the done cycle, and only then, the engine writes base+d (code 7) or base-d (code 8) to the base register.
- R10: No other mode asserts rf_we_o, and rf_we_o is never high outside a done cycle.
- R11: mem_req_o stays high with a stable mem_addr_o until mem_valid_i is seen. done_o follows one cycle after the last valid. A start that arrives while the engine is busy is ignored.
- R12: done_o is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operand fetch; taken only when idle |
| mode_i | input | 4 | Addressing mode code |
| base_sel_i | input | RW | Base register selector |
| idx_sel_i | input | RW | Index register selector |
| field_i | input | DW | Displacement, literal or absolute address |
| size_i | input | 2 | Operand size code |
| done_o | output | 1 | Operand ready pulse |
| opnd_o | output | DW | Operand value, valid with done_o |
| rf_raddr_a_o | output | RW | Register read port A address (base) |
| rf_rdata_a_i | input | DW | Register read port A data |
| rf_raddr_b_o | output | RW | Register read port B address (index) |
| rf_rdata_b_i | input | DW | Register read port B data |
| rf_we_o | output | 1 | Register write enable |
| rf_waddr_o | output | RW | Register write address |
| rf_wdata_o | output | DW | Register write data |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | DW | Memory read address |
| mem_valid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | DW | Memory read data |

## Verification
The bench builds the engine with its defaults: a 32-bit data path and sixteen registers. This makes the full 32-bit address arithmetic reachable, including wrap-around on post-decrement and scaled sums. It also allows distinct base and index selectors across the whole register file. The bench answers memory requests after zero, one, two or three cycles of delay, so the hold-until-valid rule and the two-stage indirect fetch are tested under stalls. A mid-operation start is injected to show that it is ignored.

// File: rtl/opnd_pkg.sv
package opnd_pkg;
  typedef enum logic [3:0] {
    MD_REG   = 4'd0,
    MD_IMM   = 4'd1,
    MD_DISP  = 4'd2,
    MD_RIND  = 4'd3,
    MD_INDEX = 4'd4,
    MD_ABS   = 4'd5,
    MD_MIND  = 4'd6,
    MD_AINC  = 4'd7,
    MD_ADEC  = 4'd8,
    MD_SCALE = 4'd9
  } mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_RD1,
    SQ_RD2,
    SQ_DONE
  } seq_state_e;

  // size code -> log2(d); codes 2 and 3 both mean 4 bytes
  function automatic logic [1:0] size_shift(input logic [1:0] sz);
    return (sz == 2'd0) ? 2'd0 : (sz == 2'd1) ? 2'd1 : 2'd2;
  endfunction
endpackage

// File: rtl/opnd_ea_gen.sv
module opnd_ea_gen
  import opnd_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [3:0]    mode_i,
  input  logic [DW-1:0] base_i,
  input  logic [DW-1:0] idx_i,
  input  logic [DW-1:0] field_i,
  input  logic [1:0]    shift_i,
  output logic [DW-1:0] ea_o,
  output logic [DW-1:0] direct_o,
  output logic          mem_o,
  output logic          indir_o,
  output logic          wb_o,
  output logic          dec_o
);
  localparam int NSH = 3;

  logic [DW-1:0] scaled [NSH];
  logic [DW-1:0] idx_scaled;

  for (genvar g = 0; g < NSH; g++) begin : g_scale
    assign scaled[g] = idx_i << g;
  end

  assign idx_scaled = (shift_i == 2'd0) ? scaled[0] :
                      (shift_i == 2'd1) ? scaled[1] : scaled[2];

  always_comb begin
    ea_o     = base_i;
    direct_o = base_i;
    mem_o    = 1'b0;
    indir_o  = 1'b0;
    wb_o     = 1'b0;
    dec_o    = 1'b0;
    case (mode_i)
      MD_IMM:   direct_o = field_i;
      MD_DISP:  begin mem_o = 1'b1; ea_o = field_i + base_i; end
      MD_RIND:  mem_o = 1'b1;
      MD_INDEX: begin mem_o = 1'b1; ea_o = base_i + idx_i; end
      MD_ABS:   begin mem_o = 1'b1; ea_o = field_i; end
      MD_MIND:  begin mem_o = 1'b1; indir_o = 1'b1; end
      MD_AINC:  begin mem_o = 1'b1; wb_o = 1'b1; end
      MD_ADEC:  begin mem_o = 1'b1; wb_o = 1'b1; dec_o = 1'b1; end
      MD_SCALE: begin mem_o = 1'b1; ea_o = field_i + base_i + idx_scaled; end
      default:  ;
    endcase
  end
endmodule

// File: rtl/opnd_seq.sv
module opnd_seq
  import opnd_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          need_mem_i,
  input  logic          indir_i,
  input  logic [DW-1:0] ea_i,
  input  logic [DW-1:0] direct_i,
  input  logic          mem_valid_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_req_o,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] opnd_o,
  output logic          done_o,
  output logic          busy_o,
  output logic          accept_o
);
  seq_state_e    state_q;
  logic [DW-1:0] addr_q;
  logic [DW-1:0] res_q;
  logic          lvl2_q;

  assign accept_o   = start_i && (state_q == SQ_IDLE);
  assign busy_o     = (state_q != SQ_IDLE);
  assign mem_req_o  = (state_q == SQ_RD1) || (state_q == SQ_RD2);
  assign mem_addr_o = addr_q;
  assign done_o     = (state_q == SQ_DONE);
  assign opnd_o     = res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      addr_q  <= '0;
      res_q   <= '0;
      lvl2_q  <= 1'b0;
    end else begin
      case (state_q)
        SQ_IDLE: if (accept_o) begin
          if (need_mem_i) begin
            addr_q  <= ea_i;
            lvl2_q  <= indir_i;
            state_q <= SQ_RD1;
          end else begin
            res_q   <= direct_i;
            state_q <= SQ_DONE;
          end
        end
        SQ_RD1: if (mem_valid_i) begin
          if (lvl2_q) begin
            addr_q  <= mem_rdata_i;  // pointer fetched, chase it
            state_q <= SQ_RD2;
          end else begin
            res_q   <= mem_rdata_i;
            state_q <= SQ_DONE;
          end
        end
        SQ_RD2: if (mem_valid_i) begin
          res_q   <= mem_rdata_i;
          state_q <= SQ_DONE;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/opnd_wb.sv
module opnd_wb #(
  parameter int DW = 32,
  parameter int RW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          wb_i,
  input  logic          dec_i,
  input  logic [RW-1:0] sel_i,
  input  logic [DW-1:0] base_i,
  input  logic [1:0]    shift_i,
  input  logic          done_i,
  output logic          rf_we_o,
  output logic [RW-1:0] rf_waddr_o,
  output logic [DW-1:0] rf_wdata_o
);
  logic          wb_q;
  logic [RW-1:0] sel_q;
  logic [DW-1:0] val_q;
  logic [DW-1:0] step;

  assign step = {{(DW-1){1'b0}}, 1'b1} << shift_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_q  <= 1'b0;
      sel_q <= '0;
      val_q <= '0;
    end else if (accept_i) begin
      wb_q  <= wb_i;
      sel_q <= sel_i;
      val_q <= dec_i ? (base_i - step) : (base_i + step);
    end
  end

  // update lands with done, after the read has completed
  assign rf_we_o    = done_i && wb_q;
  assign rf_waddr_o = sel_q;
  assign rf_wdata_o = val_q;
endmodule

// File: rtl/opnd_addr_engine.sv
module opnd_addr_engine
  import opnd_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 16,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [3:0]    mode_i,
  input  logic [RW-1:0] base_sel_i,
  input  logic [RW-1:0] idx_sel_i,
  input  logic [DW-1:0] field_i,
  input  logic [1:0]    size_i,
  output logic          done_o,
  output logic [DW-1:0] opnd_o,
  output logic [RW-1:0] rf_raddr_a_o,
  input  logic [DW-1:0] rf_rdata_a_i,
  output logic [RW-1:0] rf_raddr_b_o,
  input  logic [DW-1:0] rf_rdata_b_i,
  output logic          rf_we_o,
  output logic [RW-1:0] rf_waddr_o,
  output logic [DW-1:0] rf_wdata_o,
  output logic          mem_req_o,
  output logic [DW-1:0] mem_addr_o,
  input  logic          mem_valid_i,
  input  logic [DW-1:0] mem_rdata_i
);
  logic [1:0]    shamt;
  logic [DW-1:0] ea;
  logic [DW-1:0] direct;
  logic          need_mem;
  logic          indir;
  logic          wb_en;
  logic          wb_dec;
  logic          accept;
  logic          busy;

  assign rf_raddr_a_o = base_sel_i;
  assign rf_raddr_b_o = idx_sel_i;
  assign shamt        = size_shift(size_i);

  opnd_ea_gen #(.DW(DW)) i_ea_gen (
    .mode_i   (mode_i),
    .base_i   (rf_rdata_a_i),
    .idx_i    (rf_rdata_b_i),
    .field_i  (field_i),
    .shift_i  (shamt),
    .ea_o     (ea),
    .direct_o (direct),
    .mem_o    (need_mem),
    .indir_o  (indir),
    .wb_o     (wb_en),
    .dec_o    (wb_dec)
  );

  opnd_seq #(.DW(DW)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .need_mem_i  (need_mem),
    .indir_i     (indir),
    .ea_i        (ea),
    .direct_i    (direct),
    .mem_valid_i (mem_valid_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .opnd_o      (opnd_o),
    .done_o      (done_o),
    .busy_o      (busy),
    .accept_o    (accept)
  );

  opnd_wb #(.DW(DW), .RW(RW)) i_wb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .wb_i       (wb_en),
    .dec_i      (wb_dec),
    .sel_i      (base_sel_i),
    .base_i     (rf_rdata_a_i),
    .shift_i    (shamt),
    .done_i     (done_o),
    .rf_we_o    (rf_we_o),
    .rf_waddr_o (rf_waddr_o),
    .rf_wdata_o (rf_wdata_o)
  );
endmodule

// File: rtl/opnd_addr_engine_chk.sv
module opnd_addr_engine_chk #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [3:0]    mode_i,
  input logic          busy_i,
  input logic          done_o,
  input logic          rf_we_o,
  input logic          mem_req_o,
  input logic [DW-1:0] mem_addr_o,
  input logic          mem_valid_i
);
  p_direct_one_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i && (mode_i == 4'd0 || mode_i == 4'd1)) |=> (done_o && !mem_req_o));

  p_we_only_at_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> done_o);

  p_req_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_no_req_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mem_req_o);

  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind opnd_addr_engine opnd_addr_engine_chk #(.DW(DW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .mode_i      (mode_i),
  .busy_i      (busy),
  .done_o      (done_o),
  .rf_we_o     (rf_we_o),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_valid_i (mem_valid_i)
);

// File: tb/test_opnd_addr_engine.sv
`timescale 1ns/1ps
module test_opnd_addr_engine;
  localparam int DW = 32;
  localparam int NREG = 16;
  localparam int RW = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [3:0]    mode_i = '0;
  logic [RW-1:0] base_sel_i = '0;
  logic [RW-1:0] idx_sel_i = '0;
  logic [DW-1:0] field_i = '0;
  logic [1:0]    size_i = '0;
  logic          done_o;
  logic [DW-1:0] opnd_o;
  logic [RW-1:0] rf_raddr_a_o, rf_raddr_b_o, rf_waddr_o;
  logic [DW-1:0] rf_rdata_a_i, rf_rdata_b_i, rf_wdata_o;
  logic          rf_we_o;
  logic          mem_req_o;
  logic [DW-1:0] mem_addr_o;
  logic          mem_valid_i = 1'b0;
  logic [DW-1:0] mem_rdata_i = '0;

  logic [DW-1:0] regs [NREG];
  int n_chk = 0;
  int n_fail = 0;
  int cyc_total = 0;

  always #4 clk = ~clk;

  assign rf_rdata_a_i = regs[rf_raddr_a_o];
  assign rf_rdata_b_i = regs[rf_raddr_b_o];
  always @(posedge clk) if (rf_we_o) regs[rf_waddr_o] <= rf_wdata_o;

  opnd_addr_engine i_opnd_addr_engine (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .base_sel_i(base_sel_i), .idx_sel_i(idx_sel_i), .field_i(field_i), .size_i(size_i),
    .done_o(done_o), .opnd_o(opnd_o),
    .rf_raddr_a_o(rf_raddr_a_o), .rf_rdata_a_i(rf_rdata_a_i),
    .rf_raddr_b_o(rf_raddr_b_o), .rf_rdata_b_i(rf_rdata_b_i),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_valid_i(mem_valid_i), .mem_rdata_i(mem_rdata_i)
  );

  function automatic logic [DW-1:0] mem_f(input logic [DW-1:0] a);
    return (a * 32'd2654435761) ^ 32'h5A3C_0F96;
  endfunction

  function automatic logic [DW-1:0] dsize(input logic [1:0] s);
    return (s == 2'd0) ? 32'd1 : (s == 2'd1) ? 32'd2 : 32'd4;  // R7
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference: expected addresses, result, write-back; compared every cycle
  task automatic run_op(input logic [3:0] md, input int b, input int x, input logic [DW-1:0] fld,
                        input logic [1:0] sz, input int lat, input bit glitch, input string tag);
    logic [DW-1:0] base, idx, a1, a2, res, wbv;
    int nhs, hs, wcnt, cyc;
    bit wb, exp_done, fin;
    base = regs[b]; idx = regs[x];
    a1 = base; a2 = '0; nhs = 1; wb = 0; wbv = '0;
    case (md)
      4'd1: begin nhs = 0; res = fld; end
      4'd2: begin a1 = fld + base; res = mem_f(a1); end
      4'd3: res = mem_f(a1);
      4'd4: begin a1 = base + idx; res = mem_f(a1); end
      4'd5: begin a1 = fld; res = mem_f(a1); end
      4'd6: begin nhs = 2; a2 = mem_f(base); res = mem_f(a2); end
      4'd7: begin res = mem_f(a1); wb = 1; wbv = base + dsize(sz); end
      4'd8: begin res = mem_f(a1); wb = 1; wbv = base - dsize(sz); end
      4'd9: begin a1 = fld + base + idx * dsize(sz); res = mem_f(a1); end
      default: begin nhs = 0; res = base; end
    endcase
    @(negedge clk);
    mode_i = md; base_sel_i = RW'(b); idx_sel_i = RW'(x); field_i = fld; size_i = sz; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    exp_done = (nhs == 0); hs = 0; wcnt = 0; cyc = 0; fin = 0;
    while (!fin && cyc < 40) begin
      if (glitch && cyc == 1) begin start_i = 1'b1; mode_i = 4'd1; field_i = 32'hDEAD_BEEF; end
      else start_i = 1'b0;
      chk(done_o == exp_done, {tag, " done timing"}, {31'd0, done_o}, {31'd0, exp_done});
      if (!wb) chk(rf_we_o == 1'b0, "R10 no write-back", {31'd0, rf_we_o}, 32'd0);
      if (done_o) begin
        chk(opnd_o == res, {tag, " operand"}, opnd_o, res);
        chk(hs == nhs, "R8 handshake count", hs, nhs);
        chk(mem_req_o == 1'b0, "R11 no request at done", {31'd0, mem_req_o}, 32'd0);
        if (wb) begin
          chk(rf_we_o == 1'b1, "R9 write strobe", {31'd0, rf_we_o}, 32'd1);
          chk(rf_waddr_o == RW'(b), "R9 write address", {28'd0, rf_waddr_o}, b);
          chk(rf_wdata_o == wbv, "R9 write data", rf_wdata_o, wbv);
        end
        mem_valid_i = 1'b0;
        fin = 1;
      end else begin
        if (wb) chk(rf_we_o == 1'b0, "R9 early write", {31'd0, rf_we_o}, 32'd0);
        exp_done = 0;
        if (mem_req_o) begin
          chk(mem_addr_o == ((hs == 0) ? a1 : a2), {tag, " / R11 address"}, mem_addr_o, (hs == 0) ? a1 : a2);
          if (wcnt >= lat) begin
            mem_valid_i = 1'b1; mem_rdata_i = mem_f(mem_addr_o); hs++; wcnt = 0;
            if (hs == nhs) exp_done = 1;
          end else begin
            mem_valid_i = 1'b0; wcnt++;
          end
        end else mem_valid_i = 1'b0;
        @(negedge clk);
        cyc++;
      end
    end
    if (!fin) chk(1'b0, {tag, " never done"}, 32'd0, 32'd1);
    start_i = 1'b0;
    if (wb) begin
      @(negedge clk);
      chk(regs[b] == wbv, "R9 register updated", regs[b], wbv);
    end
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) regs[i] = 32'h1000 * i + 32'h40 + i;
    regs[15] = 32'h0000_0002;
    repeat (3) @(negedge clk);
    chk(!done_o && !mem_req_o && !rf_we_o, "R1 reset idle", {29'd0, done_o, mem_req_o, rf_we_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!done_o && !mem_req_o && !rf_we_o, "R1 after release", {29'd0, done_o, mem_req_o, rf_we_o}, 32'd0);

    run_op(4'd0, 3, 0, 32'h0, 2'd0, 0, 0, "R2 register");
    run_op(4'd12, 5, 0, 32'h7, 2'd0, 0, 0, "R2 unused code");
    run_op(4'd1, 2, 0, 32'hCAFE_0123, 2'd0, 0, 0, "R3 immediate");
    run_op(4'd2, 4, 0, 32'h0000_0100, 2'd0, 1, 0, "R4 displacement");
    run_op(4'd2, 6, 0, 32'hFFFF_FFF0, 2'd0, 0, 0, "R4 negative displacement");
    run_op(4'd3, 7, 0, 32'h0, 2'd0, 2, 0, "R4 register indirect");
    run_op(4'd4, 1, 8, 32'h0, 2'd0, 0, 0, "R5 indexed");
    run_op(4'd5, 0, 0, 32'h0001_2340, 2'd0, 3, 0, "R5 absolute");
    run_op(4'd9, 2, 9, 32'h20, 2'd0, 0, 0, "R6 R7 scaled d=1");
    run_op(4'd9, 2, 9, 32'h20, 2'd1, 1, 0, "R6 R7 scaled d=2");
    run_op(4'd9, 2, 9, 32'h20, 2'd2, 0, 0, "R6 R7 scaled d=4");
    run_op(4'd9, 2, 9, 32'h20, 2'd3, 2, 0, "R6 R7 scaled code3");
    run_op(4'd6, 10, 0, 32'h0, 2'd0, 0, 0, "R8 indirect");
    run_op(4'd6, 11, 0, 32'h0, 2'd0, 2, 0, "R8 indirect stalled");
    run_op(4'd7, 12, 0, 32'h0, 2'd0, 0, 0, "R9 post-increment d=1");
    run_op(4'd7, 12, 0, 32'h0, 2'd1, 1, 0, "R9 post-increment d=2");
    run_op(4'd8, 13, 0, 32'h0, 2'd2, 0, 0, "R9 post-decrement d=4");
    run_op(4'd8, 15, 0, 32'h0, 2'd3, 2, 0, "R9 post-decrement wrap");
    run_op(4'd3, 4, 0, 32'h0, 2'd0, 3, 1, "R11 start while busy");
    run_op(4'd0, 4, 0, 32'h0, 2'd0, 0, 0, "R12 back to back");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    while (cyc_total < 100000) begin
      @(posedge clk);
      cyc_total++;
    end
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc_total);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule